// File: doc/BRIEF.md
# DRAM Refresh and Counter-Test Cycle Decoder

This block is the control side of a dynamic memory device, modelled synchronously. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable, along with an 11-bit multiplexed address. From the order of the strobe edges, the block works out which kind of cycle is running:

- a normal row/column access, with page-mode column reaccess;
- a row refresh with the row taken from the address pins (only the row strobe falls);
- a refresh where the column strobe falls first, and the row comes from an internal refresh counter.

The block drives the row, column, read-enable and write-enable controls of a memory array stub. It also drives a one-cycle refresh pulse that carries the refreshed row.

The refresh counter can be exercised directly. After a column-first refresh, the column strobe is raised and lowered again while the row strobe stays low. This opens a counter-test access. Its row is the counter value and its column is latched from the pins on that second column fall. Reads, writes and read-modify-write are all possible in this access. A test can therefore walk every row through the counter and confirm that the counter steps correctly.

The controller has eight states, listed below with the name each has in the state type:

| State | Meaning |
|---|---|
| `ST_IDLE` | both strobes high |
| `ST_ROW_OPEN` | row latched from the pins, no column yet |
| `ST_ACCESS` | normal array access |
| `ST_PAGE_WAIT` | column raised inside the row period |
| `ST_CAS_FIRST` | column low while the row strobe is high |
| `ST_REFRESH` | counter refresh in progress |
| `ST_REFRESH_HOLD` | column raised after a counter refresh |
| `ST_CTR_TEST` | counter-test access |

The named transitions are as follows:

- **open-row**: `ST_IDLE` → `ST_ROW_OPEN`.
- **col-early**: `ST_IDLE` → `ST_CAS_FIRST`.
- **pin-refresh**: `ST_ROW_OPEN` → `ST_IDLE`, on a row rise with no column fall. This pulses the refresh output and loads the counter.
- **col-latch**: `ST_ROW_OPEN` or `ST_PAGE_WAIT` → `ST_ACCESS`.
- **page-release**: `ST_ACCESS` → `ST_PAGE_WAIT`.
- **row-close**: any row-low state → `ST_IDLE`, or → `ST_CAS_FIRST` when the column strobe is still low.
- **ctr-refresh**: `ST_CAS_FIRST` → `ST_REFRESH`. This pulses the refresh output with the counter row.
- **col-abort**: `ST_CAS_FIRST` → `ST_IDLE`.
- **test-release**: `ST_REFRESH` or `ST_CTR_TEST` → `ST_REFRESH_HOLD`.
- **test-open**: `ST_REFRESH_HOLD` → `ST_CTR_TEST`.

When a row-close leaves any of the three counter-refresh states, the counter advances by one.

Top module: `dram_rfsh_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, the refresh counter reads 0. In that cycle the read, write, output-enable, test-mode and refresh-pulse outputs are all 0.
- R2: Pin refresh. The row strobe falls with the column strobe high, and then rises with no column fall in between. In the cycle after the rise is sampled, `rfsh_pulse` is 1 for exactly one cycle. `rfsh_row` then equals the address sampled at the row fall, and the counter is loaded with that row plus one, modulo 2048.
- R3: Counter refresh. The column strobe is sampled low, and afterwards the row strobe falls. In the cycle after that fall is sampled, `rfsh_pulse` is 1 for one cycle and `rfsh_row` equals the counter value.
- R4: The counter is 11 bits wide. It increments by one in the same clock edge that samples the row strobe rising at the end of a counter refresh period. It wraps from 2047 to 0. Apart from this step, it changes only by the R2 load.
- R5: Normal access. The row is latched from `addr` at the row fall and the column is latched from `addr` at the following column fall. From the cycle after the column fall, `arr_row` and `arr_col` show the latched row and column until the access ends. No refresh pulse occurs and the counter is left as it was.
- R6: Page mode. Inside one row-low period, raising the column strobe ends the access. Each later column fall latches a new column against the same row. When the row strobe then rises, no refresh pulse is produced.
- R7: Counter-test access. After a counter refresh, the column strobe rises and then falls while the row strobe stays low. From the next cycle, `test_mode` is 1 and `arr_row` equals the counter value. `arr_col` equals the address sampled at that second column fall.
- R8: During an access (normal or counter test), `arr_rd` follows `we_n` high and `arr_wr` follows `we_n` low, combinationally. A read followed by a write within one column-low period is therefore a read-modify-write.
- R9: `dq_oe` is 1 exactly when an access is active, `oe_n` is low and `we_n` is high. Otherwise the data pins are treated as high impedance.
- R10: When the row strobe is sampled high, the next cycle has no access: `arr_rd`, `arr_wr`, `dq_oe` and `test_mode` are all 0.
- R11: Hidden refresh. The row strobe rises while the column strobe is still low, then falls again. This is a counter refresh, as in R3, and it advances the counter, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (11) | Multiplexed row/column address |
| arr_row | output | AW | Row presented to the array |
| arr_col | output | AW | Column presented to the array |
| arr_rd | output | 1 | Array read enable |
| arr_wr | output | 1 | Array write enable |
| dq_oe | output | 1 | Data output drive enable |
| test_mode | output | 1 | Counter-test access in progress |
| rfsh_pulse | output | 1 | One-cycle refresh indication |
| rfsh_row | output | AW | Row refreshed, valid with `rfsh_pulse` |
| rfsh_ctr | output | AW | Current refresh counter value |

## Verification
The checker assumes the following about the block's inputs:

- Every strobe level is held for at least one clock sample.
- The row and column strobes never fall in the same sample.
- The column strobe never falls in the same sample as the row strobe rises, except where R11 allows a hidden refresh.
- All strobes are high while reset is asserted.

The stimulus tasks change one strobe per clock step from the falling clock edge. They raise both strobes together only when closing a cycle, so every sequence the bench applies lies inside these limits.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    // Strobe bit positions inside the edge detector vector
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_N   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_ACCESS,
        ST_PAGE_WAIT,
        ST_CAS_FIRST,
        ST_REFRESH,
        ST_REFRESH_HOLD,
        ST_CTR_TEST
    } cyc_state_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b1;
            end else begin
                prev_q[g] <= lvl_n[g];
            end
        end

        assign fall[g] =  prev_q[g] & ~lvl_n[g];
        assign rise[g] = ~prev_q[g] &  lvl_n[g];
    end

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] seed_row,
    input  logic          step,
    output logic [AW-1:0] count
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= seed_row + ONE;
        end else if (step) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_fall,
    input  logic          ras_rise,
    input  logic          cas_fall,
    input  logic          cas_rise,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ctr,
    output logic          ctr_load,
    output logic          ctr_step,
    output logic [AW-1:0] seed_row,
    output logic [AW-1:0] arr_row,
    output logic [AW-1:0] arr_col,
    output logic          arr_rd,
    output logic          arr_wr,
    output logic          dq_oe,
    output logic          test_mode,
    output logic          rfsh_pulse,
    output logic [AW-1:0] rfsh_row
);

    cyc_state_t    st_q, st_d;
    logic [AW-1:0] row_q, col_q;
    logic          take_row, take_col;
    logic          pulse_d;
    logic [AW-1:0] pulse_row_d;

    // Next-state and event decode
    always_comb begin
        st_d        = st_q;
        take_row    = 1'b0;
        take_col    = 1'b0;
        pulse_d     = 1'b0;
        pulse_row_d = ctr;
        ctr_load    = 1'b0;
        ctr_step    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ras_fall) begin
                    st_d     = ST_ROW_OPEN;
                    take_row = 1'b1;
                end else if (cas_fall) begin
                    st_d = ST_CAS_FIRST;
                end
            end
            ST_ROW_OPEN: begin
                if (ras_rise) begin
                    st_d        = ST_IDLE;
                    pulse_d     = 1'b1;
                    pulse_row_d = row_q;
                    ctr_load    = 1'b1;
                end else if (cas_fall) begin
                    st_d     = ST_ACCESS;
                    take_col = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (ras_rise) begin
                    st_d = cas_rise ? ST_IDLE : ST_CAS_FIRST;
                end else if (cas_rise) begin
                    st_d = ST_PAGE_WAIT;
                end
            end
            ST_PAGE_WAIT: begin
                if (ras_rise) begin
                    st_d = cas_fall ? ST_CAS_FIRST : ST_IDLE;
                end else if (cas_fall) begin
                    st_d     = ST_ACCESS;
                    take_col = 1'b1;
                end
            end
            ST_CAS_FIRST: begin
                if (ras_fall) begin
                    st_d    = ST_REFRESH;
                    pulse_d = 1'b1;
                end else if (cas_rise) begin
                    st_d = ST_IDLE;
                end
            end
            ST_REFRESH: begin
                if (ras_rise) begin
                    st_d     = cas_rise ? ST_IDLE : ST_CAS_FIRST;
                    ctr_step = 1'b1;
                end else if (cas_rise) begin
                    st_d = ST_REFRESH_HOLD;
                end
            end
            ST_REFRESH_HOLD: begin
                if (ras_rise) begin
                    st_d     = cas_fall ? ST_CAS_FIRST : ST_IDLE;
                    ctr_step = 1'b1;
                end else if (cas_fall) begin
                    st_d     = ST_CTR_TEST;
                    take_col = 1'b1;
                end
            end
            ST_CTR_TEST: begin
                if (ras_rise) begin
                    st_d     = cas_rise ? ST_IDLE : ST_CAS_FIRST;
                    ctr_step = 1'b1;
                end else if (cas_rise) begin
                    st_d = ST_REFRESH_HOLD;
                end
            end
        endcase
    end

    assign seed_row = row_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Address latches and refresh indication
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q      <= '0;
            col_q      <= '0;
            rfsh_pulse <= 1'b0;
            rfsh_row   <= '0;
        end else begin
            if (take_row) row_q <= addr;
            if (take_col) col_q <= addr;
            rfsh_pulse <= pulse_d;
            if (pulse_d) rfsh_row <= pulse_row_d;
        end
    end

    // Outputs
    always_comb begin
        logic active;
        active    = (st_q == ST_ACCESS) || (st_q == ST_CTR_TEST);
        test_mode = (st_q == ST_CTR_TEST);
        arr_row   = test_mode ? ctr : row_q;
        arr_col   = col_q;
        arr_rd    = active &  we_n;
        arr_wr    = active & ~we_n;
        dq_oe     = active &  we_n & ~oe_n;
    end

endmodule

// File: rtl/dram_rfsh_decoder.sv
module dram_rfsh_decoder
    import dram_rfsh_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] arr_row,
    output logic [AW-1:0] arr_col,
    output logic          arr_rd,
    output logic          arr_wr,
    output logic          dq_oe,
    output logic          test_mode,
    output logic          rfsh_pulse,
    output logic [AW-1:0] rfsh_row,
    output logic [AW-1:0] rfsh_ctr
);

    logic [STB_N-1:0] stb_n, stb_fall, stb_rise;
    logic             ctr_load, ctr_step;
    logic [AW-1:0]    seed_row;

    always_comb begin
        stb_n          = '1;
        stb_n[STB_RAS] = ras_n;
        stb_n[STB_CAS] = cas_n;
    end

    strobe_edge #(.N(STB_N)) edge_i (
        .clk   (clk),
        .rst   (rst),
        .lvl_n (stb_n),
        .fall  (stb_fall),
        .rise  (stb_rise)
    );

    cycle_fsm #(.AW(AW)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .ras_fall   (stb_fall[STB_RAS]),
        .ras_rise   (stb_rise[STB_RAS]),
        .cas_fall   (stb_fall[STB_CAS]),
        .cas_rise   (stb_rise[STB_CAS]),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .ctr        (rfsh_ctr),
        .ctr_load   (ctr_load),
        .ctr_step   (ctr_step),
        .seed_row   (seed_row),
        .arr_row    (arr_row),
        .arr_col    (arr_col),
        .arr_rd     (arr_rd),
        .arr_wr     (arr_wr),
        .dq_oe      (dq_oe),
        .test_mode  (test_mode),
        .rfsh_pulse (rfsh_pulse),
        .rfsh_row   (rfsh_row)
    );

    rfsh_row_counter #(.AW(AW)) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .seed_row (seed_row),
        .step     (ctr_step),
        .count    (rfsh_ctr)
    );

endmodule

// File: rtl/dram_rfsh_decoder_chk.sv
module dram_rfsh_decoder_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          ras_n,
    input logic          cas_n,
    input logic [AW-1:0] arr_row,
    input logic          arr_rd,
    input logic          arr_wr,
    input logic          test_mode,
    input logic          rfsh_pulse,
    input logic [AW-1:0] rfsh_row,
    input logic [AW-1:0] rfsh_ctr
);

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        rfsh_pulse |=> !rfsh_pulse);

    // R4
    ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rfsh_ctr != $past(rfsh_ctr)) |->
            ((AW'(rfsh_ctr - $past(rfsh_ctr)) == AW'(1)) ||
             (rfsh_pulse && (rfsh_ctr == AW'(rfsh_row + AW'(1))))));

    // R7
    test_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(test_mode) |-> ($past(!ras_n) && $past(!cas_n)));

    // R10
    ras_high_close_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ras_n) |-> !(arr_rd || arr_wr || test_mode));

    // R5
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((arr_rd || arr_wr) && $past(arr_rd || arr_wr) && !$past(ras_n))
            |-> $stable(arr_row));

endmodule

bind dram_rfsh_decoder dram_rfsh_decoder_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .arr_row    (arr_row),
    .arr_rd     (arr_rd),
    .arr_wr     (arr_wr),
    .test_mode  (test_mode),
    .rfsh_pulse (rfsh_pulse),
    .rfsh_row   (rfsh_row),
    .rfsh_ctr   (rfsh_ctr)
);

// File: tb/dram_rfsh_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_decoder_tb_top;

    localparam int AW   = 11;
    localparam int ROWS = 2048;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] arr_row, arr_col, rfsh_row, rfsh_ctr;
    logic          arr_rd, arr_wr, dq_oe, test_mode, rfsh_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dram_rfsh_decoder #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .arr_row(arr_row), .arr_col(arr_col),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .dq_oe(dq_oe), .test_mode(test_mode),
        .rfsh_pulse(rfsh_pulse), .rfsh_row(rfsh_row), .rfsh_ctr(rfsh_ctr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Behavioural reference: tracks what the current row-low period is
    bit m_pr = 1, m_pc = 1;
    bit m_ctr_period = 0, m_colseen = 0, m_acc = 0, m_pulse = 0;
    int m_row = 0, m_col = 0, m_ctr = 0, m_prow = 0;

    always @(posedge clk) begin
        m_pulse = 0;
        if (rst) begin
            m_pr = 1; m_pc = 1; m_ctr_period = 0; m_colseen = 0; m_acc = 0;
            m_row = 0; m_col = 0; m_ctr = 0; m_prow = 0;
        end else begin
            if (m_pr && !ras_n) begin
                m_acc = 0;
                if (!cas_n) begin
                    m_ctr_period = 1; m_pulse = 1; m_prow = m_ctr;
                end else begin
                    m_ctr_period = 0; m_colseen = 0; m_row = int'(addr);
                end
            end else if (!m_pr && ras_n) begin
                if (m_ctr_period) begin
                    m_ctr = (m_ctr + 1) % ROWS;
                end else if (!m_colseen) begin
                    m_pulse = 1; m_prow = m_row; m_ctr = (m_row + 1) % ROWS;
                end
                m_acc = 0; m_ctr_period = 0;
            end else if (!ras_n) begin
                if (m_pc && !cas_n) begin
                    m_colseen = 1; m_col = int'(addr); m_acc = 1;
                end else if (!m_pc && cas_n) begin
                    m_acc = 0;
                end
            end
            m_pr = ras_n; m_pc = cas_n;
        end
        #2;
        chk("R8 arr_rd", int'(arr_rd), int'(m_acc && we_n));
        chk("R8 arr_wr", int'(arr_wr), int'(m_acc && !we_n));
        chk("R9 dq_oe", int'(dq_oe), int'(m_acc && we_n && !oe_n));
        chk("R7 test_mode", int'(test_mode), int'(m_acc && m_ctr_period));
        chk("R3 rfsh_pulse", int'(rfsh_pulse), int'(m_pulse));
        chk("R4 rfsh_ctr", int'(rfsh_ctr), m_ctr);
        if (m_pulse) chk("R3 rfsh_row", int'(rfsh_row), m_prow);
        if (m_acc) begin
            chk("R5 arr_row", int'(arr_row), m_ctr_period ? m_ctr : m_row);
            chk("R5 arr_col", int'(arr_col), m_col);
        end
    end

    task automatic step(input bit r, input bit c, input bit w, input bit o, input int a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = AW'(a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 1, 1, 0);
    endtask

    task automatic ras_only(input int row);
        step(0, 1, 1, 1, row);
        step(0, 1, 1, 1, row);
        step(1, 1, 1, 1, 0);
        idle(1);
    endtask

    task automatic plain_cbr();
        step(1, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(1, 1, 1, 1, 0);
        idle(1);
    endtask

    // Counter-test access with read then write in the same column-low period
    task automatic ctr_test(input int col, input int exp_row, input bit probe);
        step(1, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(0, 1, 1, 1, 0);
        step(0, 0, 1, 0, col);
        step(0, 0, 1, 0, col);
        if (probe) begin
            #1;
            chk("R7 test row", int'(arr_row), exp_row);
            chk("R7 test col", int'(arr_col), col);
            chk("R8 rmw read", int'(arr_rd), 1);
        end
        step(0, 0, 0, 1, col);
        if (probe) begin
            #5;
            chk("R8 rmw write", int'(arr_wr), 1);
        end
        step(0, 0, 0, 1, col);
        step(1, 1, 1, 1, 0);
        step(1, 1, 1, 1, 0);
        if (probe) begin
            #1;
            chk("R10 test cleared", int'(test_mode), 0);
            chk("R10 no access", int'(arr_rd | arr_wr), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 ctr after reset", int'(rfsh_ctr), 0);
        chk("R1 pulse after reset", int'(rfsh_pulse), 0);
        chk("R1 access after reset", int'(arr_rd | arr_wr | dq_oe | test_mode), 0);
        idle(2);

        // Counter initialisation by pin refresh
        for (int r = 0; r < 8; r++) ras_only(r + 3);
        #1;
        chk("R2 counter loaded", int'(rfsh_ctr), 11);

        // Normal write then read, row 100 col 5
        step(0, 1, 1, 1, 100);
        step(0, 0, 0, 1, 5);
        step(0, 0, 0, 1, 5);
        step(1, 1, 1, 1, 0);
        step(0, 1, 1, 1, 100);
        step(0, 0, 1, 0, 5);
        step(0, 0, 1, 0, 5);
        #1;
        chk("R5 normal row", int'(arr_row), 100);
        chk("R9 dq_oe on read", int'(dq_oe), 1);

        // Page mode: second column against same row
        step(0, 1, 1, 1, 0);
        step(0, 0, 1, 1, 77);
        step(0, 0, 1, 1, 77);
        #1;
        chk("R6 page col", int'(arr_col), 77);
        chk("R6 page row", int'(arr_row), 100);
        step(1, 1, 1, 1, 0);
        step(1, 1, 1, 1, 0);
        #1;
        chk("R6 no refresh after page", int'(rfsh_ctr), 11);

        // Counter-test accesses
        for (int k = 0; k < 20; k++) ctr_test(k * 37, 11 + k, 1'b1);
        #1;
        chk("R4 after tests", int'(rfsh_ctr), 31);

        // Wrap
        ras_only(2045);
        for (int k = 0; k < 3; k++) plain_cbr();
        #1;
        chk("R4 wrap", int'(rfsh_ctr), 1);

        // Hidden refresh after a normal read
        step(0, 1, 1, 1, 9);
        step(0, 0, 1, 0, 4);
        step(0, 0, 1, 0, 4);
        step(1, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(1, 1, 1, 1, 0);
        idle(1);
        #1;
        chk("R11 hidden refresh step", int'(rfsh_ctr), 2);

        // Full walk through every row with counter-test accesses
        ras_only(0);
        for (int k = 0; k < ROWS; k++) ctr_test(5, (1 + k) % ROWS, (k % 256) == 0);
        #1;
        chk("R4 full walk", int'(rfsh_ctr), 1);

        idle(3);
        summary();
    end

endmodule